// File: doc/BRIEF.md
# Blocking Token Channel Endpoint

This block is one end of a full-duplex, point-to-point channel. Traffic in each direction is a stream of 9-bit tokens: an 8-bit value plus a flag that marks it as either data or control. A local thread talks to the endpoint through a single request port. That port has four operations: send a word, send a token, receive a word and receive a token. The endpoint talks to its peer through two independent token links, one outbound and one inbound. Each link is valid/ready. A token moves on a cycle where both valid and ready are high. A sender must hold the token stable while ready is low.

A thread request is valid/ready as well. The request completes on the rising edge where both `req_valid` and `req_ready` are high. The response fields are valid in that same cycle. While a request is waiting, the matching stall pin is high. A send waits until the transmit buffer has room for every token of the request. A receive waits until the receive buffer holds what the request needs. Control tokens travel in-band. One control value marks the end of a message. While any message is open, the endpoint holds its outbound path, and it releases the path when that end marker leaves.

Top module: `chan_end`

## Requirements
- R1: A word send (`req_op` = 2'b00) puts four tokens on the outbound link, all with the control flag clear. Bits 7:0 go first and bits 31:24 go last.
- R2: A token send (`req_op` = 2'b01) puts exactly one token on the outbound link. Its value is `req_data[7:0]` and its flag is `req_ctl`.
- R3: A word send completes only when the 8-deep transmit buffer has at least four free slots. Until then, `req_ready` is low, `tx_stall` is high and no token of that word is queued.
- R4: A token send completes only when at least one transmit slot is free. Otherwise `tx_stall` is high.
- R5: The inbound link is ready whenever the 8-deep receive buffer is not full, and ready is low when it is full. Tokens leave the buffer in arrival order, including on cycles where a token arrives and a read removes tokens.
- R6: A token receive (`req_op` = 2'b11) completes once one token is buffered. It returns the oldest token's value in `rsp_data[7:0]` (upper bits zero) and its flag in `rsp_ctl`. While the buffer is empty, `rx_stall` is high.
- R7: A word receive (`req_op` = 2'b10) completes once four data tokens are at the head of the buffer. It returns them assembled with the oldest token in bits 7:0, and `rsp_err` is low.
- R8: If a word receive finds a control token among the buffered head tokens (up to four), it completes at once with `rsp_err` high and removes nothing. Later token receives return the same tokens.
- R9: `route_held` rises after any token leaves on the outbound link. It falls only after a control token with value 8'h01 (end of message) leaves.
- R10: Reset empties both buffers, drops outbound valid, raises inbound ready and clears `route_held`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Thread request present |
| req_op | input | 2 | 00 word send, 01 token send, 10 word receive, 11 token receive |
| req_data | input | 32 | Send payload |
| req_ctl | input | 1 | Control flag for a token send |
| req_ready | output | 1 | Request completes this cycle |
| rsp_data | output | 32 | Received word or token |
| rsp_ctl | output | 1 | Flag of the received token |
| rsp_err | output | 1 | Word receive hit a control token |
| tx_stall | output | 1 | A send request is waiting for space |
| rx_stall | output | 1 | A receive request is waiting for tokens |
| lk_tx_tok | output | 8 | Outbound token value |
| lk_tx_ctl | output | 1 | Outbound token is control |
| lk_tx_valid | output | 1 | Outbound token present |
| lk_tx_ready | input | 1 | Peer takes outbound token |
| lk_rx_tok | input | 8 | Inbound token value |
| lk_rx_ctl | input | 1 | Inbound token is control |
| lk_rx_valid | input | 1 | Inbound token present |
| lk_rx_ready | output | 1 | Endpoint takes inbound token |
| route_held | output | 1 | Outbound message open |

## Verification
The receive buffer can take a token from the link in the same cycle that a word or token read removes tokens. The transmit buffer can likewise queue a word while it hands its head token to the link. Two endpoints are wired back to back, and both thread sides run a random stream of mixed words, data tokens and control tokens, with random gaps, so both overlaps recur often. Each result is compared with a scoreboard queue that the writer fills, so any lost, repeated or reordered token shows up as a mismatch.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int TOK_W     = 8;
  localparam int WORD_W    = 32;
  localparam int WORD_TOKS = WORD_W / TOK_W;

  typedef struct packed {
    logic             ctl;
    logic [TOK_W-1:0] data;
  } tok_t;

  typedef enum logic [1:0] {
    OP_SEND_WORD = 2'b00,
    OP_SEND_TOK  = 2'b01,
    OP_RECV_WORD = 2'b10,
    OP_RECV_TOK  = 2'b11
  } op_e;
endpackage

// File: rtl/chan_tok_fifo.sv
// Token queue: up to MAXN pushes and MAXN pops per cycle, MAXN-token head window.
// DEPTH must be a power of two (pointers wrap naturally).
module chan_tok_fifo
  import chan_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int MAXN  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(MAXN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NW-1:0]         push_n,
  input  tok_t [MAXN-1:0]       push_tok,
  input  logic [NW-1:0]         pop_n,
  output tok_t [MAXN-1:0]       head,
  output logic [CW-1:0]         count
);
  tok_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      for (int k = 0; k < MAXN; k++) begin
        if (NW'(k) < push_n) mem[wr_ptr + AW'(k)] <= push_tok[k];
      end
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_comb begin
    for (int k = 0; k < MAXN; k++) head[k] = mem[rd_ptr + AW'(k)];
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != '0) |-> (int'(count) - int'(pop_n) + int'(push_n) <= DEPTH));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(count));
endmodule

// File: rtl/chan_tx_side.sv
module chan_tx_side
  import chan_pkg::*;
#(
  parameter int          DEPTH    = 8,
  parameter logic [7:0]  END_CODE = 8'h01,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(WORD_TOKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_ctl,
  output logic              wr_accept,
  output logic [TOK_W-1:0]  lk_tok,
  output logic              lk_ctl,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic              route_held
);
  tok_t [WORD_TOKS-1:0] push_tok, head;
  logic [NW-1:0]        push_n, pop_n;
  logic [CW-1:0]        count;
  logic                 pop;
  int                   need;

  always_comb begin
    for (int k = 0; k < WORD_TOKS; k++) begin
      push_tok[k].ctl  = 1'b0;
      push_tok[k].data = wr_data[k*TOK_W +: TOK_W];
    end
    if (!wr_word) push_tok[0].ctl = wr_ctl;
  end

  assign need      = wr_word ? WORD_TOKS : 1;
  assign wr_accept = wr_valid && (int'(count) + need <= DEPTH);
  assign push_n    = wr_accept ? NW'(need) : '0;
  assign lk_valid  = (count != '0);
  assign lk_tok    = head[0].data;
  assign lk_ctl    = head[0].ctl;
  assign pop       = lk_valid && lk_ready;
  assign pop_n     = pop ? NW'(1) : '0;

  chan_tok_fifo #(.DEPTH(DEPTH), .MAXN(WORD_TOKS)) u_q (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_tok(push_tok),
    .pop_n(pop_n), .head(head), .count(count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) route_held <= 1'b0;
    else if (pop) route_held <= !(head[0].ctl && head[0].data == END_CODE);
  end

  assert_link_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |=> (lk_valid && $stable({lk_ctl, lk_tok})));
  assert_route_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(route_held) |-> $past(lk_valid && lk_ready && lk_ctl && lk_tok == END_CODE));
endmodule

// File: rtl/chan_rx_side.sv
module chan_rx_side
  import chan_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(WORD_TOKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_word,
  output logic              rd_accept,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_ctl,
  output logic              rd_err,
  input  logic [TOK_W-1:0]  lk_tok,
  input  logic              lk_ctl,
  input  logic              lk_valid,
  output logic              lk_ready
);
  tok_t [WORD_TOKS-1:0] push_tok, head;
  logic [NW-1:0]        push_n, pop_n;
  logic [CW-1:0]        count;
  logic                 ctl_seen;
  logic [WORD_W-1:0]    word;

  always_comb begin
    for (int k = 0; k < WORD_TOKS; k++) begin
      push_tok[k].ctl  = lk_ctl;
      push_tok[k].data = lk_tok;
    end
  end

  assign lk_ready = (int'(count) < DEPTH);
  assign push_n   = (lk_valid && lk_ready) ? NW'(1) : '0;

  always_comb begin
    ctl_seen = 1'b0;
    for (int k = 0; k < WORD_TOKS; k++) begin
      word[k*TOK_W +: TOK_W] = head[k].data;
      if (k < int'(count) && head[k].ctl) ctl_seen = 1'b1;
    end
  end

  always_comb begin
    rd_accept = 1'b0;
    rd_err    = 1'b0;
    rd_ctl    = 1'b0;
    rd_data   = '0;
    pop_n     = '0;
    if (rd_valid) begin
      if (rd_word) begin
        if (ctl_seen) begin
          rd_accept = 1'b1;
          rd_err    = 1'b1;
        end else if (int'(count) >= WORD_TOKS) begin
          rd_accept = 1'b1;
          rd_data   = word;
          pop_n     = NW'(WORD_TOKS);
        end
      end else if (count != '0) begin
        rd_accept            = 1'b1;
        rd_data[TOK_W-1:0]   = head[0].data;
        rd_ctl               = head[0].ctl;
        pop_n                = NW'(1);
      end
    end
  end

  chan_tok_fifo #(.DEPTH(DEPTH), .MAXN(WORD_TOKS)) u_q (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_tok(push_tok),
    .pop_n(pop_n), .head(head), .count(count)
  );

  assert_err_keeps_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && rd_err) |=> (int'(count) == int'($past(count)) + int'($past(push_n))));
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !lk_ready);
endmodule

// File: rtl/chan_end.sv
module chan_end
  import chan_pkg::*;
#(
  parameter int         TX_DEPTH = 8,
  parameter int         RX_DEPTH = 8,
  parameter logic [7:0] END_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [WORD_W-1:0] req_data,
  input  logic              req_ctl,
  output logic              req_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_ctl,
  output logic              rsp_err,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic [TOK_W-1:0]  lk_tx_tok,
  output logic              lk_tx_ctl,
  output logic              lk_tx_valid,
  input  logic              lk_tx_ready,
  input  logic [TOK_W-1:0]  lk_rx_tok,
  input  logic              lk_rx_ctl,
  input  logic              lk_rx_valid,
  output logic              lk_rx_ready,
  output logic              route_held
);
  op_e  op;
  logic is_send, tx_acc, rx_acc;

  assign op      = op_e'(req_op);
  assign is_send = (op == OP_SEND_WORD) || (op == OP_SEND_TOK);

  chan_tx_side #(.DEPTH(TX_DEPTH), .END_CODE(END_CODE)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(req_valid && is_send), .wr_word(op == OP_SEND_WORD),
    .wr_data(req_data), .wr_ctl(req_ctl), .wr_accept(tx_acc),
    .lk_tok(lk_tx_tok), .lk_ctl(lk_tx_ctl), .lk_valid(lk_tx_valid),
    .lk_ready(lk_tx_ready), .route_held(route_held)
  );

  chan_rx_side #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(req_valid && !is_send), .rd_word(op == OP_RECV_WORD),
    .rd_accept(rx_acc), .rd_data(rsp_data), .rd_ctl(rsp_ctl), .rd_err(rsp_err),
    .lk_tok(lk_rx_tok), .lk_ctl(lk_rx_ctl), .lk_valid(lk_rx_valid),
    .lk_ready(lk_rx_ready)
  );

  assign req_ready = is_send ? tx_acc : rx_acc;
  assign tx_stall  = req_valid && is_send && !tx_acc;
  assign rx_stall  = req_valid && !is_send && !rx_acc;

  assert_stall_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_stall && rx_stall) && !(req_ready && (tx_stall || rx_stall)));
  assert_send_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && is_send) |-> !rsp_err);
endmodule

// File: tb/tb_chan_end.sv
module tb_chan_end;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic        th_valid [2];
  logic [1:0]  th_op    [2];
  logic [31:0] th_data  [2];
  logic        th_ctl   [2];
  logic        th_ready [2];
  logic [31:0] th_rdata [2];
  logic        th_rctl  [2];
  logic        th_err   [2];
  logic        stall_tx [2];
  logic        stall_rx [2];
  logic        held     [2];

  logic [7:0] ab_tok, ba_tok;
  logic ab_ctl, ab_valid, ab_ready, ba_ctl, ba_valid, ba_ready;

  chan_end dut (
    .clk(clk), .rst_n(rst_n), .req_valid(th_valid[0]), .req_op(th_op[0]),
    .req_data(th_data[0]), .req_ctl(th_ctl[0]), .req_ready(th_ready[0]),
    .rsp_data(th_rdata[0]), .rsp_ctl(th_rctl[0]), .rsp_err(th_err[0]),
    .tx_stall(stall_tx[0]), .rx_stall(stall_rx[0]),
    .lk_tx_tok(ab_tok), .lk_tx_ctl(ab_ctl), .lk_tx_valid(ab_valid), .lk_tx_ready(ab_ready),
    .lk_rx_tok(ba_tok), .lk_rx_ctl(ba_ctl), .lk_rx_valid(ba_valid), .lk_rx_ready(ba_ready),
    .route_held(held[0])
  );

  chan_end dut_peer (
    .clk(clk), .rst_n(rst_n), .req_valid(th_valid[1]), .req_op(th_op[1]),
    .req_data(th_data[1]), .req_ctl(th_ctl[1]), .req_ready(th_ready[1]),
    .rsp_data(th_rdata[1]), .rsp_ctl(th_rctl[1]), .rsp_err(th_err[1]),
    .tx_stall(stall_tx[1]), .rx_stall(stall_rx[1]),
    .lk_tx_tok(ba_tok), .lk_tx_ctl(ba_ctl), .lk_tx_valid(ba_valid), .lk_tx_ready(ba_ready),
    .lk_rx_tok(ab_tok), .lk_rx_ctl(ab_ctl), .lk_rx_valid(ab_valid), .lk_rx_ready(ab_ready),
    .route_held(held[1])
  );

  localparam logic [1:0] SW = 2'b00, ST = 2'b01, RW = 2'b10, RT = 2'b11;

  int n_tests = 0;
  int n_fail  = 0;

  logic [1:0]  exp_op   [$];
  logic [31:0] exp_data [$];
  logic        exp_ctl  [$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int i, input logic [1:0] op, input logic [31:0] d,
                       input logic c, output logic [31:0] rd, output logic rc,
                       output logic re);
    @(negedge clk);
    th_valid[i] = 1'b1; th_op[i] = op; th_data[i] = d; th_ctl[i] = c;
    #1;
    while (!th_ready[i]) begin
      @(negedge clk);
      #1;
    end
    rd = th_rdata[i]; rc = th_rctl[i]; re = th_err[i];
    @(posedge clk);
    #1 th_valid[i] = 1'b0;
  endtask

  task automatic send(input int i, input logic [1:0] op, input logic [31:0] d, input logic c);
    logic [31:0] rd; logic rc, re;
    do_op(i, op, d, c, rd, rc, re);
  endtask

  task automatic recv(input int i, input logic [1:0] op, input string req,
                      input logic [31:0] ed, input logic ec, input logic ee);
    logic [31:0] rd; logic rc, re;
    do_op(i, op, 32'h0, 1'b0, rd, rc, re);
    check(req, "data", rd, ed);
    check(req, "ctl", {31'b0, rc}, {31'b0, ec});
    check(req, "err", {31'b0, re}, {31'b0, ee});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      th_valid[i] = 1'b0; th_op[i] = 2'b00; th_data[i] = '0; th_ctl[i] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10", "tx valid", {31'b0, ab_valid}, 32'h0);
    check("R10", "rx ready", {31'b0, ab_ready}, 32'h1);
    check("R10", "route", {31'b0, held[0]}, 32'h0);

    // R1 word goes out low byte first, as data tokens
    send(0, SW, 32'h44332211, 1'b0);
    recv(1, RT, "R1", 32'h11, 1'b0, 1'b0);
    recv(1, RT, "R1", 32'h22, 1'b0, 1'b0);
    recv(1, RT, "R1", 32'h33, 1'b0, 1'b0);
    recv(1, RT, "R1", 32'h44, 1'b0, 1'b0);

    // R2 single control token
    send(0, ST, 32'h5A, 1'b1);
    recv(1, RT, "R2", 32'h5A, 1'b1, 1'b0);

    // R7 word assembled from single tokens, both directions
    send(0, ST, 32'hAA, 1'b0); send(0, ST, 32'hBB, 1'b0);
    send(0, ST, 32'hCC, 1'b0); send(0, ST, 32'hDD, 1'b0);
    recv(1, RW, "R7", 32'hDDCCBBAA, 1'b0, 1'b0);
    send(1, SW, 32'hCAFEF00D, 1'b0);
    recv(0, RW, "R7", 32'hCAFEF00D, 1'b0, 1'b0);

    // R8 control inside a word read: error, stream untouched
    send(0, ST, 32'h77, 1'b0);
    send(0, ST, 32'h02, 1'b1);
    repeat (4) @(posedge clk);
    recv(1, RW, "R8", 32'h0, 1'b0, 1'b1);
    recv(1, RT, "R8", 32'h77, 1'b0, 1'b0);
    recv(1, RT, "R8", 32'h02, 1'b1, 1'b0);

    // R6 read on empty buffer stalls
    fork
      recv(1, RT, "R6", 32'h99, 1'b0, 1'b0);
      begin
        repeat (10) @(negedge clk);
        #1;
        check("R6", "rx_stall", {31'b0, stall_rx[1]}, 32'h1);
        check("R6", "tx_stall", {31'b0, stall_tx[1]}, 32'h0);
        send(0, ST, 32'h99, 1'b0);
      end
    join

    // R3 / R4 / R5 blocking with full buffers
    for (int w = 0; w < 4; w++) send(0, SW, 32'h10101010 * (w + 1), 1'b0);
    repeat (10) @(posedge clk);
    fork
      send(0, SW, 32'h50505050, 1'b0);
      begin
        repeat (20) @(negedge clk);
        #1;
        check("R3", "tx_stall", {31'b0, stall_tx[0]}, 32'h1);
        check("R3", "req_ready", {31'b0, th_ready[0]}, 32'h0);
        check("R5", "rx full ready", {31'b0, ab_ready}, 32'h0);
        recv(1, RW, "R3", 32'h10101010, 1'b0, 1'b0);
      end
    join
    fork
      send(0, ST, 32'h66, 1'b0);
      begin
        repeat (10) @(negedge clk);
        #1;
        check("R4", "tx_stall", {31'b0, stall_tx[0]}, 32'h1);
        recv(1, RW, "R4", 32'h20202020, 1'b0, 1'b0);
      end
    join
    recv(1, RW, "R3", 32'h30303030, 1'b0, 1'b0);
    recv(1, RW, "R3", 32'h40404040, 1'b0, 1'b0);
    recv(1, RW, "R3", 32'h50505050, 1'b0, 1'b0);
    recv(1, RT, "R4", 32'h66, 1'b0, 1'b0);

    // R9 path held until end marker leaves
    @(negedge clk); #1;
    check("R9", "held", {31'b0, held[0]}, 32'h1);
    send(0, ST, 32'h01, 1'b1);
    recv(1, RT, "R9", 32'h01, 1'b1, 1'b0);
    repeat (3) @(negedge clk); #1;
    check("R9", "released", {31'b0, held[0]}, 32'h0);

    // R5 random stream with same-cycle arrival and removal
    fork
      begin
        for (int n = 0; n < 60; n++) begin
          int kind;
          logic [31:0] d;
          repeat ($urandom_range(0, 3)) @(posedge clk);
          kind = $urandom_range(0, 2);
          d = $urandom;
          if (kind == 0) begin
            exp_op.push_back(RW); exp_data.push_back(d); exp_ctl.push_back(1'b0);
            send(0, SW, d, 1'b0);
          end else if (kind == 1) begin
            exp_op.push_back(RT); exp_data.push_back({24'b0, d[7:0]}); exp_ctl.push_back(1'b0);
            send(0, ST, {24'b0, d[7:0]}, 1'b0);
          end else begin
            d = 32'($urandom_range(2, 255));
            exp_op.push_back(RT); exp_data.push_back(d); exp_ctl.push_back(1'b1);
            send(0, ST, d, 1'b1);
          end
        end
      end
      begin
        for (int n = 0; n < 60; n++) begin
          logic [1:0] op; logic [31:0] d; logic c;
          while (exp_op.size() == 0) @(posedge clk);
          op = exp_op.pop_front(); d = exp_data.pop_front(); c = exp_ctl.pop_front();
          repeat ($urandom_range(0, 3)) @(posedge clk);
          recv(1, op, "R5", d, c, 1'b0);
        end
      end
    join

    finish_run();
  end
endmodule